// File: doc/BRIEF.md
# Interrupt Pin Dispatcher with End-of-Interrupt Tracking

This block watches a bank of interrupt input lines (24 by default) and turns line activity into interrupt messages for the processor-side interrupt controllers. Each line has a routing entry that a separate register block drives. The entry holds a vector, a destination, a destination mode, a delivery mode, a trigger kind (edge or level), an inversion bit and a mask. The block holds a request bit per line and decides when that line needs service. Serviced lines are sent one at a time over a valid/ready message port.

Level-triggered lines carry a remote-pending flag. It is set when a message for that line is accepted. While it is set, the line cannot raise a new message. An end-of-interrupt command names a vector. Every line whose entry holds that vector receives a one-cycle acknowledge pulse. For level-triggered lines the command also clears remote-pending, and if the line is still active and unmasked it is delivered again. The register block can also ask for a line to be serviced, for example after it rewrites that line's entry. Line 0 is always sent to processor 0 in physical mode.

Top module: `intr_pin_dispatch`

## Requirements
- R1: The effective level of a line is `line_in` XOR `cfg_invert`. When the effective level is inactive, the line's request bit is cleared, so a later end-of-interrupt on that level line sends nothing.
- R2: An edge-triggered, unmasked line sends exactly one message for each rising edge of its effective level. Holding the level high sends nothing further.
- R3: A level-triggered, unmasked line whose effective level is active and whose remote-pending bit is clear sends a message. When that message is accepted, `remote_pend` for the line becomes 1.
- R4: While a level line's `remote_pend` bit is 1, an active line sends no new message by itself.
- R5: One cycle after `eoi_valid` is high, `eoi_ack` is 1 for every line whose entry vector equals `eoi_vector` and 0 for all other lines. Matching level lines have `remote_pend` cleared in that same cycle. Edge lines never set `remote_pend`.
- R6: After an end-of-interrupt, a matching level line that is still active and unmasked is delivered again.
- R7: A masked line sends no message. The service of a masked edge line drops its request, so a later service request after unmasking sends nothing. A masked level line that is still active sends a message once it is unmasked.
- R8: The message carries the entry's vector, destination, destination mode (1 = logical), trigger kind (1 = level) and delivery mode. For line 0, the destination is forced to 0 and the mode to physical (0).
- R9: A pulse on `svc_req[i]` while line i's request bit is set services that line exactly as line activity would, even when remote-pending is 1.
- R10: Lines that need service at the same time are sent in ascending line order, one message per accepted handshake.
- R11: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid` stays 1 and all message fields stay unchanged.
- R12: After reset, `msg_valid`, `eoi_ack` and `remote_pend` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | NUM_PINS | Raw interrupt lines |
| cfg_vector | input | NUM_PINS*VEC_W | Vector of each entry |
| cfg_dest | input | NUM_PINS*DEST_W | Destination of each entry |
| cfg_logical | input | NUM_PINS | Destination mode, 1 = logical |
| cfg_level | input | NUM_PINS | Trigger kind, 1 = level |
| cfg_dlv | input | NUM_PINS*DLV_W | Delivery mode of each entry |
| cfg_invert | input | NUM_PINS | Line polarity inversion |
| cfg_mask | input | NUM_PINS | Entry mask, 1 = masked |
| svc_req | input | NUM_PINS | Service request from the register block |
| eoi_valid | input | 1 | End-of-interrupt command strobe |
| eoi_vector | input | VEC_W | Vector named by the command |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted when high with msg_valid |
| msg_vector | output | VEC_W | Message vector |
| msg_dest | output | DEST_W | Message destination |
| msg_logical | output | 1 | Message destination mode |
| msg_level | output | 1 | Message trigger kind |
| msg_dlv | output | DLV_W | Message delivery mode |
| eoi_ack | output | NUM_PINS | Per-line acknowledge pulse |
| remote_pend | output | NUM_PINS | Remote-pending flags |

## Verification
An edge on every one of the 24 lines is swept, each with its own polarity, destination and delivery mode. This checks the XOR with the inversion bit, the copying of each field and the line 0 override, and the wait after each edge shows that a held level does not repeat. Level lines are driven in both polarities through the full cycle: deliver, hold off, end-of-interrupt with the line still active, then end-of-interrupt with the line dropped. This separates redelivery from the clearing of the request. Simultaneous edges with the consumer stalled show ordering and message hold. A masked edge followed by unmask and a service request, and a masked level line that is later unmasked, show the two different masking outcomes. Commands that match two lines at once, or edge lines only, check the acknowledge vector without any change to remote-pending.

// File: rtl/ipd_pkg.sv
package ipd_pkg;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int DLV_W  = 3;

  typedef struct packed {
    logic [VEC_W-1:0]  vector;
    logic [DEST_W-1:0] dest;
    logic              logical;
    logic              level;
    logic [DLV_W-1:0]  dlv;
  } ipd_msg_t;
endpackage

// File: rtl/ipd_pin.sv
// Per-line request, remote-pending and service-pending state.
module ipd_pin
  import ipd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw,
  input  logic             invert,
  input  logic             level_trig,
  input  logic             masked,
  input  logic [VEC_W-1:0] vector,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  input  logic             svc_req,
  input  logic             grant,
  input  logic             accept,
  input  logic             inflight,
  output logic             pend,
  output logic             rp,
  output logic             ack
);
  logic eff, eff_q, rise, eoi_hit;
  logic irr_q, irr_d, rp_q, rp_d, pend_q, pend_d, ack_q;
  logic t_line, t_svc, t_eoi;

  always_comb begin
    eff     = raw ^ invert;
    rise    = eff & ~eff_q;
    eoi_hit = eoi_valid && (eoi_vector == vector);

    // request bit
    if (!eff)            irr_d = 1'b0;
    else if (level_trig) irr_d = 1'b1;
    else if (rise)       irr_d = 1'b1;
    else if (grant)      irr_d = 1'b0;
    else                 irr_d = irr_q;

    // remote pending
    rp_d = rp_q;
    if (level_trig && eoi_hit) rp_d = 1'b0;
    if (level_trig && accept)  rp_d = 1'b1;

    // service triggers
    t_line = level_trig ? (eff & ~masked & ~rp_q & ~pend_q & ~inflight) : rise;
    t_svc  = svc_req & irr_q;
    t_eoi  = eoi_hit & level_trig & ~masked & irr_q;
    pend_d = (pend_q & ~grant) | t_line | t_svc | t_eoi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q  <= 1'b0;
      irr_q  <= 1'b0;
      rp_q   <= 1'b0;
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      eff_q  <= eff;
      irr_q  <= irr_d;
      rp_q   <= rp_d;
      pend_q <= pend_d;
      ack_q  <= eoi_hit;
    end
  end

  assign pend = pend_q;
  assign rp   = rp_q;
  assign ack  = ack_q;
endmodule

// File: rtl/ipd_pick.sv
// Lowest-index selector over the service-pending vector.
module ipd_pick #(
  parameter int NUM_PINS = 24,
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic [NUM_PINS-1:0] req,
  output logic                found,
  output logic [PIN_W-1:0]    idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = NUM_PINS - 1; k >= 0; k--) begin
      if (req[k]) begin
        found = 1'b1;
        idx   = PIN_W'(k);
      end
    end
  end
endmodule

// File: rtl/ipd_msg.sv
// Single-entry message holding stage with valid/ready handshake.
module ipd_msg
  import ipd_pkg::*;
#(
  parameter int PIN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  ipd_msg_t         load_msg,
  input  logic [PIN_W-1:0] load_idx,
  input  logic             ready,
  output logic             valid,
  output ipd_msg_t         msg,
  output logic [PIN_W-1:0] idx
);
  logic             valid_q, valid_d;
  ipd_msg_t         msg_q, msg_d;
  logic [PIN_W-1:0] idx_q, idx_d;

  always_comb begin
    valid_d = valid_q;
    msg_d   = msg_q;
    idx_d   = idx_q;
    if (valid_q && ready) valid_d = 1'b0;
    if (load) begin
      valid_d = 1'b1;
      msg_d   = load_msg;
      idx_d   = load_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      msg_q   <= '0;
      idx_q   <= '0;
    end else begin
      valid_q <= valid_d;
      msg_q   <= msg_d;
      idx_q   <= idx_d;
    end
  end

  assign valid = valid_q;
  assign msg   = msg_q;
  assign idx   = idx_q;
endmodule

// File: rtl/intr_pin_dispatch.sv
module intr_pin_dispatch
  import ipd_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PINS-1:0]        line_in,
  input  logic [NUM_PINS*VEC_W-1:0]  cfg_vector,
  input  logic [NUM_PINS*DEST_W-1:0] cfg_dest,
  input  logic [NUM_PINS-1:0]        cfg_logical,
  input  logic [NUM_PINS-1:0]        cfg_level,
  input  logic [NUM_PINS*DLV_W-1:0]  cfg_dlv,
  input  logic [NUM_PINS-1:0]        cfg_invert,
  input  logic [NUM_PINS-1:0]        cfg_mask,
  input  logic [NUM_PINS-1:0]        svc_req,
  input  logic                       eoi_valid,
  input  logic [VEC_W-1:0]           eoi_vector,
  output logic                       msg_valid,
  input  logic                       msg_ready,
  output logic [VEC_W-1:0]           msg_vector,
  output logic [DEST_W-1:0]          msg_dest,
  output logic                       msg_logical,
  output logic                       msg_level,
  output logic [DLV_W-1:0]           msg_dlv,
  output logic [NUM_PINS-1:0]        eoi_ack,
  output logic [NUM_PINS-1:0]        remote_pend
);
  logic [NUM_PINS-1:0] pend, grant, accept, inflight;
  logic                found, take, slot_free, load;
  logic [PIN_W-1:0]    sel_idx, held_idx;
  ipd_msg_t            load_msg, cur_msg;

  ipd_pick #(.NUM_PINS(NUM_PINS)) u_pick (
    .req(pend), .found(found), .idx(sel_idx)
  );

  assign slot_free = ~msg_valid | msg_ready;
  assign take      = found & slot_free;
  assign load      = take & ~cfg_mask[sel_idx];

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign grant[g]    = take && (sel_idx == PIN_W'(g));
    assign inflight[g] = msg_valid && (held_idx == PIN_W'(g));
    assign accept[g]   = inflight[g] && msg_ready;

    ipd_pin u_pin (
      .clk        (clk),
      .rst_n      (rst_n),
      .raw        (line_in[g]),
      .invert     (cfg_invert[g]),
      .level_trig (cfg_level[g]),
      .masked     (cfg_mask[g]),
      .vector     (cfg_vector[g*VEC_W +: VEC_W]),
      .eoi_valid  (eoi_valid),
      .eoi_vector (eoi_vector),
      .svc_req    (svc_req[g]),
      .grant      (grant[g]),
      .accept     (accept[g]),
      .inflight   (inflight[g]),
      .pend       (pend[g]),
      .rp         (remote_pend[g]),
      .ack        (eoi_ack[g])
    );
  end

  // Message build; line 0 is pinned to processor 0, physical mode.
  always_comb begin
    load_msg.vector  = cfg_vector[sel_idx*VEC_W +: VEC_W];
    load_msg.dest    = cfg_dest[sel_idx*DEST_W +: DEST_W];
    load_msg.logical = cfg_logical[sel_idx];
    load_msg.level   = cfg_level[sel_idx];
    load_msg.dlv     = cfg_dlv[sel_idx*DLV_W +: DLV_W];
    if (sel_idx == '0) begin
      load_msg.dest    = '0;
      load_msg.logical = 1'b0;
    end
  end

  ipd_msg #(.PIN_W(PIN_W)) u_msg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_msg (load_msg),
    .load_idx (sel_idx),
    .ready    (msg_ready),
    .valid    (msg_valid),
    .msg      (cur_msg),
    .idx      (held_idx)
  );

  assign msg_vector  = cur_msg.vector;
  assign msg_dest    = cur_msg.dest;
  assign msg_logical = cur_msg.logical;
  assign msg_level   = cur_msg.level;
  assign msg_dlv     = cur_msg.dlv;
endmodule

// File: rtl/ipd_chk.sv
module ipd_chk
  import ipd_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [VEC_W-1:0]    msg_vector,
  input logic [DEST_W-1:0]   msg_dest,
  input logic                msg_logical,
  input logic                msg_level,
  input logic [DLV_W-1:0]    msg_dlv,
  input logic                eoi_valid,
  input logic [NUM_PINS-1:0] eoi_ack,
  input logic [NUM_PINS-1:0] remote_pend
);
  // R11
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) &&
      $stable(msg_dest) && $stable(msg_logical) && $stable(msg_level) && $stable(msg_dlv));

  // R5
  a_r5_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_ack != '0) |-> $past(eoi_valid));

  // R5
  a_r5_rp_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ((~remote_pend & $past(remote_pend)) != '0) |-> $past(eoi_valid));

  // R3
  a_r3_rp_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ((remote_pend & ~$past(remote_pend)) != '0) |-> $past(msg_valid && msg_ready));

  // R3
  a_r3_rp_single: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(remote_pend & ~$past(remote_pend)) <= 1);
endmodule

bind intr_pin_dispatch ipd_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .msg_valid   (msg_valid),
  .msg_ready   (msg_ready),
  .msg_vector  (msg_vector),
  .msg_dest    (msg_dest),
  .msg_logical (msg_logical),
  .msg_level   (msg_level),
  .msg_dlv     (msg_dlv),
  .eoi_valid   (eoi_valid),
  .eoi_ack     (eoi_ack),
  .remote_pend (remote_pend)
);

// File: tb/intr_pin_dispatch_test.sv
module intr_pin_dispatch_test;
  localparam int N = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  line_in, cfg_logical, cfg_level, cfg_invert, cfg_mask, svc_req;
  logic [N*8-1:0] cfg_vector, cfg_dest;
  logic [N*3-1:0] cfg_dlv;
  logic          eoi_valid, msg_ready, msg_valid, msg_logical, msg_level;
  logic [7:0]    eoi_vector, msg_vector, msg_dest;
  logic [2:0]    msg_dlv;
  logic [N-1:0]  eoi_ack, remote_pend;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intr_pin_dispatch #(.NUM_PINS(N)) uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .cfg_vector(cfg_vector),
    .cfg_dest(cfg_dest), .cfg_logical(cfg_logical), .cfg_level(cfg_level),
    .cfg_dlv(cfg_dlv), .cfg_invert(cfg_invert), .cfg_mask(cfg_mask),
    .svc_req(svc_req), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_dest(msg_dest), .msg_logical(msg_logical), .msg_level(msg_level),
    .msg_dlv(msg_dlv), .eoi_ack(eoi_ack), .remote_pend(remote_pend)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic set_entry(input int p, input int vec, input int dst, input bit lg,
                           input bit lvl, input int dlv, input bit inv, input bit msk);
    cfg_vector[p*8 +: 8] = vec[7:0];
    cfg_dest[p*8 +: 8]   = dst[7:0];
    cfg_logical[p]       = lg;
    cfg_level[p]         = lvl;
    cfg_dlv[p*3 +: 3]    = dlv[2:0];
    cfg_invert[p]        = inv;
    cfg_mask[p]          = msk;
    line_in[p]           = inv;
  endtask

  task automatic wait_msg(input int lim, output bit got);
    got = 0;
    for (int k = 0; k < lim && !got; k++) begin
      @(negedge clk);
      if (msg_valid) got = 1;
    end
  endtask

  task automatic no_msg(input int lim, output bit seen);
    seen = 0;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (msg_valid) seen = 1;
    end
  endtask

  task automatic send_eoi(input int vec);
    eoi_valid  = 1'b1;
    eoi_vector = vec[7:0];
    @(negedge clk);
    eoi_valid  = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit got, seen;
    rst_n = 1'b0;
    line_in = '0; cfg_logical = '0; cfg_level = '0; cfg_invert = '0;
    cfg_mask = '1; svc_req = '0; cfg_vector = '0; cfg_dest = '0; cfg_dlv = '0;
    eoi_valid = 1'b0; eoi_vector = '0; msg_ready = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R12
    chk(!msg_valid && eoi_ack == '0 && remote_pend == '0, "R12 reset state",
        {msg_valid, eoi_ack, remote_pend}, 0);

    // Sweep every line as an edge line: R1 R2 R8
    for (int i = 0; i < N; i++) begin
      int vec, dst, dlv;
      bit lg, inv;
      vec = 32 + i; dst = i * 5 + 3; dlv = i % 8; lg = i[0]; inv = i[1];
      set_entry(i, vec, dst, lg, 1'b0, dlv, inv, 1'b0);
      tick(2);
      line_in[i] = ~inv;
      wait_msg(10, got);
      begin
        int edst; bit elg;
        edst = (i == 0) ? 0 : dst;
        elg  = (i == 0) ? 1'b0 : lg;
        chk(got && msg_vector == vec[7:0] && msg_dest == edst[7:0] &&
            msg_logical == elg && !msg_level && msg_dlv == dlv[2:0],
            $sformatf("R8 R1 fields line %0d", i),
            {got, msg_vector, msg_dest, msg_logical, msg_level, msg_dlv},
            {1'b1, vec[7:0], edst[7:0], elg, 1'b0, dlv[2:0]});
      end
      no_msg(6, seen);
      chk(!seen, $sformatf("R2 no repeat line %0d", i), seen, 0);
      cfg_mask[i] = 1'b1;
      line_in[i]  = inv;
      tick(1);
    end

    // Ordering and hold under stall: R10 R11
    set_entry(3, 8'h43, 1, 0, 0, 0, 0, 0);
    set_entry(7, 8'h47, 2, 0, 0, 0, 0, 0);
    set_entry(12, 8'h4C, 3, 0, 0, 0, 0, 0);
    msg_ready = 1'b0;
    tick(2);
    line_in[3] = 1'b1; line_in[7] = 1'b1; line_in[12] = 1'b1;
    wait_msg(10, got);
    chk(got && msg_vector == 8'h43, "R10 first lowest line", msg_vector, 8'h43);
    tick(4);
    chk(msg_valid && msg_vector == 8'h43 && msg_dest == 8'd1, "R11 held under stall",
        {msg_valid, msg_vector}, {1'b1, 8'h43});
    msg_ready = 1'b1;
    wait_msg(10, got);
    chk(got && msg_vector == 8'h47, "R10 second line", msg_vector, 8'h47);
    wait_msg(10, got);
    chk(got && msg_vector == 8'h4C, "R10 third line", msg_vector, 8'h4C);
    no_msg(6, seen);
    chk(!seen, "R10 one message per line", seen, 0);
    line_in[3] = 1'b0; line_in[7] = 1'b0; line_in[12] = 1'b0;
    cfg_mask[3] = 1'b1; cfg_mask[7] = 1'b1; cfg_mask[12] = 1'b1;
    tick(2);

    // Level line cycle: R3 R4 R5 R6 R1
    set_entry(5, 8'h55, 9, 0, 1, 1, 0, 0);
    tick(2);
    line_in[5] = 1'b1;
    wait_msg(10, got);
    chk(got && msg_vector == 8'h55 && msg_level && msg_dlv == 3'd1, "R3 level message",
        {got, msg_vector, msg_level}, {1'b1, 8'h55, 1'b1});
    tick(1);
    chk(remote_pend == 24'h000020, "R3 remote pending set", remote_pend, 24'h000020);
    no_msg(8, seen);
    chk(!seen, "R4 held off while pending", seen, 0);
    send_eoi(8'h55);
    chk(eoi_ack == 24'h000020, "R5 ack on match", eoi_ack, 24'h000020);
    wait_msg(10, got);
    chk(got && msg_vector == 8'h55, "R6 redelivery", {got, msg_vector}, {1'b1, 8'h55});
    tick(1);
    chk(remote_pend[5], "R6 pending again", remote_pend, 24'h000020);
    line_in[5] = 1'b0;
    tick(2);
    send_eoi(8'h55);
    chk(eoi_ack == 24'h000020, "R5 ack after drop", eoi_ack, 24'h000020);
    no_msg(8, seen);
    chk(!seen && remote_pend == '0, "R1 inactive line not redelivered",
        {seen, remote_pend}, 0);

    // Inverted level line: R1
    set_entry(9, 8'h59, 4, 1, 1, 2, 1, 0);
    tick(2);
    chk(!msg_valid, "R1 inverted idle", msg_valid, 0);
    line_in[9] = 1'b0;
    wait_msg(10, got);
    chk(got && msg_vector == 8'h59 && msg_logical, "R1 active-low level",
        {got, msg_vector}, {1'b1, 8'h59});
    tick(1);
    line_in[9] = 1'b1;
    tick(2);
    send_eoi(8'h59);
    no_msg(8, seen);
    chk(!seen && remote_pend == '0, "R5 pending cleared line idle", {seen, remote_pend}, 0);

    // Service request from register block: R9
    line_in[5] = 1'b1;
    wait_msg(10, got);
    tick(1);
    chk(got && remote_pend[5], "R9 setup", remote_pend, 24'h000020);
    no_msg(4, seen);
    svc_req[5] = 1'b1;
    @(negedge clk);
    svc_req[5] = 1'b0;
    wait_msg(10, got);
    chk(got && msg_vector == 8'h55, "R9 service despite pending", {got, msg_vector}, {1'b1, 8'h55});
    line_in[5] = 1'b0;
    tick(2);
    send_eoi(8'h55);
    tick(2);

    // Masked edge line: R7
    set_entry(14, 8'h6E, 5, 0, 0, 0, 0, 1);
    tick(2);
    line_in[14] = 1'b1;
    no_msg(8, seen);
    chk(!seen, "R7 masked edge silent", seen, 0);
    cfg_mask[14] = 1'b0;
    svc_req[14] = 1'b1;
    @(negedge clk);
    svc_req[14] = 1'b0;
    no_msg(8, seen);
    chk(!seen, "R7 dropped edge not resent", seen, 0);
    line_in[14] = 1'b0;
    cfg_mask[14] = 1'b1;

    // Masked level line later unmasked: R7
    set_entry(20, 8'h74, 7, 0, 1, 0, 0, 1);
    tick(2);
    line_in[20] = 1'b1;
    no_msg(8, seen);
    chk(!seen, "R7 masked level silent", seen, 0);
    cfg_mask[20] = 1'b0;
    wait_msg(10, got);
    chk(got && msg_vector == 8'h74, "R7 unmasked level sends", {got, msg_vector}, {1'b1, 8'h74});
    line_in[20] = 1'b0;
    tick(2);
    send_eoi(8'h74);
    tick(2);

    // Two edge lines sharing a vector: R5
    set_entry(16, 8'h66, 0, 0, 0, 0, 0, 1);
    set_entry(17, 8'h66, 0, 0, 0, 0, 0, 1);
    tick(2);
    send_eoi(8'h66);
    chk(eoi_ack == 24'h030000, "R5 ack both matches", eoi_ack, 24'h030000);
    tick(1);
    chk(eoi_ack == '0 && remote_pend == '0, "R5 pulse one cycle, edge no pending",
        {eoi_ack, remote_pend}, 0);
    send_eoi(8'h99);
    chk(eoi_ack == '0, "R5 no match no ack", eoi_ack, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule